// File: doc/BRIEF.md
# Gated Error Interrupt Collector

This block gathers error flags from two sub-units, an address-translation unit and a message-handling unit, and turns them into one mapped interrupt request toward a processor thread. Each error bit is latched and held until software clears it. Software can also force a bit through a set register, which is useful for testing the interrupt path. An error is passed on only when three enables allow it: its own per-bit enable, its sub-unit's enable bit, and a master enable bit.

Software reaches the block through a simple word-wide register port. Writes take effect at the clock edge on which the strobe is sampled. Reads are combinational.

When an allowed error is present and the mapping is valid, the block raises a request. The request carries a fixed vector, a target thread and a controller-select bit, and it stays up until the downstream side acknowledges it. After the acknowledge the source is busy. It stays quiet until software writes the interrupt-clear register, which re-arms it.

Top module: `err_irq_agg`

## Requirements
- R1: Writing the set register of a sub-unit (translation unit at address 0x0, message unit at 0x4) holds the written bits as a force value. The force value ORs into that unit's status from the following clock edge. A clear write cannot remove a bit while it is forced. After the set register is written with zero, a clear write removes the bit.
- R2: Status bits are sticky. A single-cycle error event pulse sets its bit, and the bit stays set. The clear register (0x1 / 0x5) is write-one-to-clear and removes only the bits written as 1. Status is read at the clear address, and the force value is read at the set address.
- R3: An error bit contributes to the interrupt only when the matching bit is 1 in its unit's enable register (0x2 / 0x6).
- R4: The block enable register (0x8) has the master enable at bit 0, the translation-unit enable at bit 1 and the message-unit enable at bit 2. A unit's errors contribute only while that unit's bit is set.
- R5: While the master bit of 0x8 is 0, no request is raised, even if both unit bits are set and both units hold enabled errors.
- R6: The mapping register (0x9) has valid at bit 31, target thread at bits 30:25 and controller select at bit 6. No request is raised while valid is 0.
- R7: A request presents vector 63, plus the thread and controller select captured from the mapping register at the moment the request was issued. Later writes to the mapping register do not change an outstanding request.
- R8: The request rises on the clock edge after an allowed error is latched. It then stays high until `irq_ack` is sampled high, and it is low from that edge on.
- R9: After an acknowledge, no new request is raised until the interrupt-clear register (0xA) is written, even if errors are still latched or new errors arrive.
- R10: A write to 0xA while busy re-arms the source. If an allowed error is still latched and valid is set, the request is high again from that same edge. Otherwise the source goes idle and requests again only when a new allowed error appears.
- R11: Reset clears all force, status, enable, block-enable and mapping registers to zero, and the request is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| xlat_err_evt | input | ERR_W | Translation-unit error event pulses |
| msg_err_evt | input | ERR_W | Message-unit error event pulses |
| irq_req | output | 1 | Interrupt request, held until acknowledged |
| irq_vector | output | 6 | Interrupt vector |
| irq_thread | output | 6 | Target thread ID |
| irq_ctl_sel | output | 1 | Controller select from the mapping register |
| irq_ack | input | 1 | Downstream acknowledge |

## Verification
A status bit that is lost or sticks wrongly is visible on the next read of the clear address. It also shows as a request that is missing or unexpected one edge after the event. A wrong enable or mapping decode shows up in the same cycle as a request where the stimulus table expects none, or no request where it expects one. A source state machine that forgets it is busy re-raises the request a cycle after the acknowledge, before any clear write. One that never re-arms leaves the request low right after the clear write, although errors are still pending.

// File: rtl/err_irq_pkg.sv
package err_irq_pkg;

    localparam int N_UNITS      = 2;
    localparam int UNIT_XLAT    = 0;
    localparam int UNIT_MSG     = 1;

    // register word offsets
    localparam int UNIT_STRIDE  = 4;
    localparam int OFS_SET      = 0;
    localparam int OFS_CLR      = 1;
    localparam int OFS_EN       = 2;
    localparam int ADDR_BLK     = 8;
    localparam int ADDR_MAP     = 9;
    localparam int ADDR_IRQCLR  = 10;

    // block enable bit positions
    localparam int BLK_MASTER   = 0;
    localparam int BLK_UNIT0    = 1;
    localparam int BLK_W        = BLK_UNIT0 + N_UNITS;

    // mapping register layout
    localparam int MAP_VALID_BIT  = 31;
    localparam int MAP_THREAD_LSB = 25;
    localparam int THREAD_W       = 6;
    localparam int MAP_CTL_BIT    = 6;
    localparam int VEC_W          = 6;

    typedef enum logic [1:0] {
        SRC_IDLE    = 2'd0,
        SRC_PENDING = 2'd1,
        SRC_SENT    = 2'd2
    } src_state_t;

    typedef struct packed {
        logic                valid;
        logic [THREAD_W-1:0] thread;
        logic                ctl;
    } map_t;

    function automatic map_t map_decode(input logic [31:0] w);
        map_t m;
        m.valid  = w[MAP_VALID_BIT];
        m.thread = w[MAP_THREAD_LSB +: THREAD_W];
        m.ctl    = w[MAP_CTL_BIT];
        return m;
    endfunction

    function automatic logic [31:0] map_encode(input map_t m);
        logic [31:0] w;
        w = '0;
        w[MAP_VALID_BIT]                 = m.valid;
        w[MAP_THREAD_LSB +: THREAD_W]    = m.thread;
        w[MAP_CTL_BIT]                   = m.ctl;
        return w;
    endfunction

endpackage

// File: rtl/err_unit.sv
module err_unit #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ERR_W-1:0] evt,
    input  logic [ERR_W-1:0] wdata,
    input  logic             wr_set,
    input  logic             wr_clr,
    input  logic             wr_en,
    output logic [ERR_W-1:0] force_q,
    output logic [ERR_W-1:0] status_q,
    output logic [ERR_W-1:0] en_q,
    output logic             hit
);

    logic [ERR_W-1:0] clr_mask;

    assign clr_mask = wr_clr ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            force_q  <= '0;
            status_q <= '0;
            en_q     <= '0;
        end else begin
            if (wr_set) force_q <= wdata;
            if (wr_en)  en_q    <= wdata;
            // sticky: clear first, then events and the force value OR in
            status_q <= (status_q & ~clr_mask) | evt | force_q;
        end
    end

    assign hit = |(status_q & en_q);

endmodule

// File: rtl/irq_source.sv
module irq_source
    import err_irq_pkg::*;
#(
    parameter int VECTOR = 63
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fire,
    input  map_t                map_i,
    input  logic                clear_wr,
    input  logic                ack,
    output logic                req,
    output logic [VEC_W-1:0]    vector,
    output logic [THREAD_W-1:0] thread,
    output logic                ctl,
    output logic                sent
);

    src_state_t st_q, st_d;
    logic       issue;

    always_comb begin
        st_d  = st_q;
        issue = 1'b0;
        unique case (st_q)
            SRC_IDLE: begin
                if (fire && map_i.valid) begin
                    st_d  = SRC_PENDING;
                    issue = 1'b1;
                end
            end
            SRC_PENDING: begin
                if (ack) st_d = SRC_SENT;
            end
            SRC_SENT: begin
                if (clear_wr) begin
                    if (fire && map_i.valid) begin
                        st_d  = SRC_PENDING;
                        issue = 1'b1;
                    end else begin
                        st_d  = SRC_IDLE;
                    end
                end
            end
            default: st_d = SRC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SRC_IDLE;
            thread <= '0;
            ctl    <= 1'b0;
        end else begin
            st_q <= st_d;
            if (issue) begin
                thread <= map_i.thread;
                ctl    <= map_i.ctl;
            end
        end
    end

    assign req    = (st_q == SRC_PENDING);
    assign sent   = (st_q == SRC_SENT);
    assign vector = VEC_W'(VECTOR);

endmodule

// File: rtl/err_irq_agg.sv
module err_irq_agg
    import err_irq_pkg::*;
#(
    parameter int ERR_W  = 8,
    parameter int ADDR_W = 4,
    parameter int VECTOR = 63
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [ERR_W-1:0]    xlat_err_evt,
    input  logic [ERR_W-1:0]    msg_err_evt,
    output logic                irq_req,
    output logic [VEC_W-1:0]    irq_vector,
    output logic [THREAD_W-1:0] irq_thread,
    output logic                irq_ctl_sel,
    input  logic                irq_ack
);

    logic [N_UNITS-1:0][ERR_W-1:0] unit_evt;
    logic [N_UNITS-1:0][ERR_W-1:0] unit_force;
    logic [N_UNITS-1:0][ERR_W-1:0] unit_status;
    logic [N_UNITS-1:0][ERR_W-1:0] unit_en;
    logic [N_UNITS-1:0]            unit_hit;
    logic [N_UNITS-1:0]            unit_gate;
    logic [N_UNITS-1:0]            set_wr;
    logic [N_UNITS-1:0]            clr_wr;
    logic [N_UNITS-1:0]            en_wr;
    logic [BLK_W-1:0]              blk_en_q;
    map_t                          map_q;
    logic                          blk_wr, map_wr, irq_clear_wr;
    logic                          fire;
    logic                          src_sent;

    assign unit_evt[UNIT_XLAT] = xlat_err_evt;
    assign unit_evt[UNIT_MSG]  = msg_err_evt;

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        localparam int BASE = u * UNIT_STRIDE;

        assign set_wr[u] = reg_wr && (reg_addr == ADDR_W'(BASE + OFS_SET));
        assign clr_wr[u] = reg_wr && (reg_addr == ADDR_W'(BASE + OFS_CLR));
        assign en_wr[u]  = reg_wr && (reg_addr == ADDR_W'(BASE + OFS_EN));

        err_unit #(.ERR_W(ERR_W)) u_unit (
            .clk      (clk),
            .rst      (rst),
            .evt      (unit_evt[u]),
            .wdata    (reg_wdata[ERR_W-1:0]),
            .wr_set   (set_wr[u]),
            .wr_clr   (clr_wr[u]),
            .wr_en    (en_wr[u]),
            .force_q  (unit_force[u]),
            .status_q (unit_status[u]),
            .en_q     (unit_en[u]),
            .hit      (unit_hit[u])
        );

        assign unit_gate[u] = unit_hit[u] & blk_en_q[BLK_UNIT0 + u];
    end

    assign blk_wr       = reg_wr && (reg_addr == ADDR_W'(ADDR_BLK));
    assign map_wr       = reg_wr && (reg_addr == ADDR_W'(ADDR_MAP));
    assign irq_clear_wr = reg_wr && (reg_addr == ADDR_W'(ADDR_IRQCLR));

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_en_q <= '0;
            map_q    <= '0;
        end else begin
            if (blk_wr) blk_en_q <= reg_wdata[BLK_W-1:0];
            if (map_wr) map_q    <= map_decode(reg_wdata);
        end
    end

    assign fire = blk_en_q[BLK_MASTER] & (|unit_gate);

    irq_source #(.VECTOR(VECTOR)) u_src (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .map_i    (map_q),
        .clear_wr (irq_clear_wr),
        .ack      (irq_ack),
        .req      (irq_req),
        .vector   (irq_vector),
        .thread   (irq_thread),
        .ctl      (irq_ctl_sel),
        .sent     (src_sent)
    );

    always_comb begin
        reg_rdata = '0;
        for (int u = 0; u < N_UNITS; u++) begin
            if (reg_addr == ADDR_W'(u * UNIT_STRIDE + OFS_SET))
                reg_rdata = 32'(unit_force[u]);
            if (reg_addr == ADDR_W'(u * UNIT_STRIDE + OFS_CLR))
                reg_rdata = 32'(unit_status[u]);
            if (reg_addr == ADDR_W'(u * UNIT_STRIDE + OFS_EN))
                reg_rdata = 32'(unit_en[u]);
        end
        if (reg_addr == ADDR_W'(ADDR_BLK)) reg_rdata = 32'(blk_en_q);
        if (reg_addr == ADDR_W'(ADDR_MAP)) reg_rdata = map_encode(map_q);
    end

endmodule

// File: rtl/err_irq_agg_chk.sv
module err_irq_agg_chk #(
    parameter int SW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          irq_req,
    input logic          irq_ack,
    input logic          fire,
    input logic          master,
    input logic          map_valid,
    input logic          clear_wr,
    input logic          sent,
    input logic [1:0]    clr_any,
    input logic [SW-1:0] status
);

    // R2
    sticky_status_chk: assert property (@(posedge clk) disable iff (rst)
        !(|clr_any) |=> ((status & $past(status)) == $past(status)));

    // R8
    req_held_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !irq_ack) |=> irq_req);

    // R9
    ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack) |=> !irq_req);

    // R5
    issue_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> $past(master && map_valid && fire));

    // R10
    rearm_chk: assert property (@(posedge clk) disable iff (rst)
        (sent && clear_wr && fire && map_valid) |=> irq_req);

endmodule

bind err_irq_agg err_irq_agg_chk #(.SW(2 * ERR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_req   (irq_req),
    .irq_ack   (irq_ack),
    .fire      (fire),
    .master    (blk_en_q[0]),
    .map_valid (map_q.valid),
    .clear_wr  (irq_clear_wr),
    .sent      (src_sent),
    .clr_any   (clr_wr),
    .status    (unit_status)
);

// File: tb/err_irq_agg_bench.sv
module err_irq_agg_bench;

    localparam int ERR_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_wr = 1'b0;
    logic [3:0]       reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic [ERR_W-1:0] xlat_err_evt = '0;
    logic [ERR_W-1:0] msg_err_evt = '0;
    logic             irq_req;
    logic [5:0]       irq_vector;
    logic [5:0]       irq_thread;
    logic             irq_ctl_sel;
    logic             irq_ack = 1'b0;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    err_irq_agg #(.ERR_W(ERR_W), .ADDR_W(4), .VECTOR(63)) u_err_irq_agg (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xlat_err_evt(xlat_err_evt), .msg_err_evt(msg_err_evt),
        .irq_req(irq_req), .irq_vector(irq_vector), .irq_thread(irq_thread),
        .irq_ctl_sel(irq_ctl_sel), .irq_ack(irq_ack)
    );

    // {xen[4], men[4], blk[3], valid, xev[4], mev[4], expect}
    localparam int NV = 8;
    localparam logic [20:0] VECS [NV] = '{
        {4'h1, 4'h0, 3'b111, 1'b1, 4'h1, 4'h0, 1'b1},
        {4'h0, 4'h2, 3'b111, 1'b1, 4'h0, 4'h2, 1'b1},
        {4'h1, 4'h0, 3'b111, 1'b1, 4'h2, 4'h0, 1'b0},
        {4'hF, 4'hF, 3'b101, 1'b1, 4'h1, 4'h0, 1'b0},
        {4'hF, 4'hF, 3'b011, 1'b1, 4'h0, 4'h4, 1'b0},
        {4'hF, 4'hF, 3'b110, 1'b1, 4'h1, 4'h1, 1'b0},
        {4'hF, 4'hF, 3'b111, 1'b0, 4'h1, 4'h0, 1'b0},
        {4'h8, 4'h0, 3'b011, 1'b1, 4'h8, 4'h0, 1'b1}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [ERR_W-1:0] x, input logic [ERR_W-1:0] m);
        xlat_err_evt = x; msg_err_evt = m;
        tick();
        xlat_err_evt = '0; msg_err_evt = '0;
    endtask

    task automatic ack_it();
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic check_rd(input string req, input logic [3:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;

        // R11 reset state
        check("R11 req", 32'(irq_req), 0);
        check_rd("R11 xen", 4'h2, 0);
        check_rd("R11 men", 4'h6, 0);
        check_rd("R11 blk", 4'h8, 0);
        check_rd("R11 map", 4'h9, 0);
        check_rd("R11 xstat", 4'h1, 0);

        // R1 force through set register
        wr(4'h0, 32'h10);
        tick();
        check_rd("R1 forced", 4'h1, 32'h10);
        check_rd("R1 set readback", 4'h0, 32'h10);
        wr(4'h1, 32'hFF);
        check_rd("R1 clr while forced", 4'h1, 32'h10);
        wr(4'h0, 32'h0);
        wr(4'h1, 32'hFF);
        check_rd("R1 clr after unforce", 4'h1, 32'h0);

        // R2 sticky and selective W1C
        pulse(8'h0, 8'h05);
        tick(); tick();
        check_rd("R2 sticky", 4'h5, 32'h05);
        wr(4'h5, 32'h01);
        check_rd("R2 partial clr", 4'h5, 32'h04);
        wr(4'h5, 32'hFF);
        check_rd("R2 full clr", 4'h5, 32'h00);

        // table: R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            logic [20:0] v;
            v = VECS[i];
            wr(4'h2, 32'(v[20:17]));
            wr(4'h6, 32'(v[16:13]));
            wr(4'h8, 32'(v[12:10]));
            wr(4'h9, {v[9], 31'h0});
            pulse(8'(v[8:5]), 8'(v[4:1]));
            tick();
            check($sformatf("R3/R4 R5 R6 vec%0d", i), 32'(irq_req), 32'(v[0]));
            if (irq_req) ack_it();
            wr(4'h1, 32'hFF);
            wr(4'h5, 32'hFF);
            wr(4'hA, 32'h0);
            check($sformatf("R10 idle after vec%0d", i), 32'(irq_req), 0);
        end

        // R7 mapped fields
        wr(4'h2, 32'h01);
        wr(4'h6, 32'h00);
        wr(4'h8, 32'h3);
        wr(4'h9, 32'h8000_0000 | (32'd42 << 25) | 32'h40);
        pulse(8'h01, 8'h0);
        tick();
        check("R7 req", 32'(irq_req), 1);
        check("R7 vector", 32'(irq_vector), 63);
        check("R7 thread", 32'(irq_thread), 42);
        check("R7 ctl", 32'(irq_ctl_sel), 1);

        // R8 held until ack; R7 fields captured
        wr(4'h9, 32'h8000_0000 | (32'd5 << 25));
        tick(); tick(); tick();
        check("R8 held", 32'(irq_req), 1);
        check("R7 thread kept", 32'(irq_thread), 42);
        ack_it();
        check("R8 drop after ack", 32'(irq_req), 0);

        // R9 quiet while busy
        pulse(8'h01, 8'h0);
        tick(); tick(); tick();
        check("R9 no refire", 32'(irq_req), 0);

        // R10 re-arm with error pending
        wr(4'hA, 32'h0);
        check("R10 rearm req", 32'(irq_req), 1);
        check("R10 new thread", 32'(irq_thread), 5);
        ack_it();
        wr(4'h1, 32'hFF);
        wr(4'hA, 32'h0);
        tick(); tick();
        check("R10 idle", 32'(irq_req), 0);
        pulse(8'h01, 8'h0);
        tick();
        check("R10 fires after idle", 32'(irq_req), 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule